// File: doc/BRIEF.md
# Paged Address Mapper with Power-Up Enable

This block widens the 16-bit address of an 8-bit processor to a 20-bit physical address. The processor space is cut into sixteen 4 KB pages. A small table holds one 8-bit physical page number for each page. The low twelve address bits go to the memory bus unchanged. The top four bits pick a table entry, and that entry becomes the top eight bits of the physical address. The result is a 1 MB physical space, seen through a 64 KB window.

Software programs the table through an I/O port. An external decoder asserts the active-low bank-select strobe. The entry index comes from the upper half of the port address, which is the same four address bits that drive translation. A write with bank-select stores the data bus into that entry. A read with bank-select drives the entry back onto the data bus.

The table is not cleared by reset, so its contents are unknown at power-up. A mapping-enable flag is therefore cleared by reset. While it is clear, every page maps to physical page zero, so a known boot memory is visible. The first completed configuration write sets the flag.

Top module: `page_mapper`

## Requirements
- R1: Physical address bits 11:0 always equal CPU address bits 11:0, with no clock delay.
- R2: While mapping is enabled, physical address bits 19:12 equal the table entry selected by CPU address bits 15:12, combinationally from the address.
- R3: A configuration write is a stretch of clocks in which bank-select and write are both low. At the first clock edge after that stretch ends, the data value and index last sampled inside it are stored. The index is CPU address bits 15:12. Until that edge, translation shows the previous entry.
- R4: While bank-select and read are both low, the data output-enable is 1 and the read data is the selected entry. At all other times the output-enable is 0 and the read data is 0x00.
- R5: After reset, mapping is disabled. While disabled, physical address bits 19:12 are 0x00 and a configuration read returns 0x00.
- R6: Only a completed configuration write enables mapping. Configuration reads, and write strobes without bank-select, leave it disabled.
- R7: Reset does not change table contents. An entry written before reset reads back unchanged once mapping is enabled again.
- R8: A write strobe with bank-select high does not change any table entry.
- R9: Reset assertion takes effect without a clock. Release reaches the logic through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU data bus toward the block |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bank_sel_n | input | 1 | Active-low select from the external I/O decoder |
| rdata | output | 8 | Table entry returned on a configuration read, else 0x00 |
| rdata_oe | output | 1 | High when the block drives the data bus |
| phys_addr | output | 20 | Physical memory address |

## Verification
A corrupted table entry appears only in the top eight physical address bits. It shows up in the same cycle the CPU touches that page, and also on a configuration read of that index. A sweep of every index after programming therefore exposes any bad entry or index decode.

A stuck or wrongly set enable flag shows up at once on all sixteen pages, as zero or as unknown page numbers. A write that commits early or late shows as a one-cycle mismatch of the translated page during the write strobe.

// File: rtl/page_mapper_pkg.sv
package page_mapper_pkg;
  localparam int unsigned CPU_AW   = 16;
  localparam int unsigned OFFS_W   = 12;
  localparam int unsigned IDX_W    = CPU_AW - OFFS_W;
  localparam int unsigned PFN_W    = 8;
  localparam int unsigned PHYS_AW  = PFN_W + OFFS_W;
  localparam int unsigned N_PAGES  = 1 << IDX_W;
  localparam int unsigned SYNC_LEN = 2;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pm_wr_capture.sv
module pm_wr_capture #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel_n,
  input  logic              wr_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              commit_we,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [DATA_W-1:0] commit_data
);
  logic              wr_active;
  logic              pend_q,  pend_d;
  logic [IDX_W-1:0]  idx_q,   idx_d;
  logic [DATA_W-1:0] data_q,  data_d;
  logic              cap_en;

  always_comb begin
    wr_active = !bank_sel_n && !wr_n;
    cap_en    = wr_active;
    pend_d    = wr_active;
    idx_d     = idx;
    data_d    = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      idx_q  <= idx_d;
      data_q <= data_d;
    end
  end

  assign commit_we   = pend_q && !wr_active;
  assign commit_idx  = idx_q;
  assign commit_data = data_q;
endmodule

// File: rtl/pm_page_table.sv
module pm_page_table #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic              ent_en;
    logic [DATA_W-1:0] ent_d;
    always_comb begin
      ent_en = we && (widx == IDX_W'(g));
      ent_d  = wdata;
    end
    always_ff @(posedge clk) begin
      if (ent_en) entry_q[g] <= ent_d;
    end
  end

  assign rdata = entry_q[ridx];
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import page_mapper_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [PFN_W-1:0]   cpu_wdata,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               bank_sel_n,
  output logic [PFN_W-1:0]   rdata,
  output logic               rdata_oe,
  output logic [PHYS_AW-1:0] phys_addr
);
  logic             rst_sync_n;
  logic             commit_we;
  logic [IDX_W-1:0] commit_idx;
  logic [PFN_W-1:0] commit_data;
  logic [IDX_W-1:0] page_idx;
  logic [PFN_W-1:0] table_out;
  logic [PFN_W-1:0] pfn;
  logic             map_en_q, map_en_d;

  assign page_idx = cpu_addr[CPU_AW-1:OFFS_W];

  pm_rst_sync #(.STAGES(SYNC_LEN)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pm_wr_capture #(.IDX_W(IDX_W), .DATA_W(PFN_W)) u_wr_capture (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bank_sel_n  (bank_sel_n),
    .wr_n        (wr_n),
    .idx         (page_idx),
    .wdata       (cpu_wdata),
    .commit_we   (commit_we),
    .commit_idx  (commit_idx),
    .commit_data (commit_data)
  );

  pm_page_table #(.IDX_W(IDX_W), .DATA_W(PFN_W)) u_table (
    .clk   (clk),
    .we    (commit_we),
    .widx  (commit_idx),
    .wdata (commit_data),
    .ridx  (page_idx),
    .rdata (table_out)
  );

  always_comb begin
    map_en_d = map_en_q || commit_we;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) map_en_q <= 1'b0;
    else             map_en_q <= map_en_d;
  end

  always_comb begin
    pfn       = map_en_q ? table_out : '0;
    phys_addr = {pfn, cpu_addr[OFFS_W-1:0]};
    rdata_oe  = !bank_sel_n && !rd_n;
    rdata     = rdata_oe ? pfn : '0;
  end
endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk
  import page_mapper_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rst_sync_n,
  input logic [CPU_AW-1:0]  cpu_addr,
  input logic               rd_n,
  input logic               bank_sel_n,
  input logic [PFN_W-1:0]   rdata,
  input logic               rdata_oe,
  input logic [PHYS_AW-1:0] phys_addr,
  input logic               map_en_q,
  input logic               commit_we
);
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phys_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]);

  assert_oe_only_on_read_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rdata_oe == (!bank_sel_n && !rd_n));

  assert_idle_bus_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rdata_oe |-> rdata == '0);

  assert_disabled_page_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !map_en_q |-> (phys_addr[PHYS_AW-1:OFFS_W] == '0 && rdata == '0));

  assert_enable_needs_commit_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(map_en_q) |-> $past(commit_we));

  assert_enable_sticks_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    map_en_q |=> map_en_q);

  assert_async_reset_R9: assert property (@(posedge clk)
    !rst_n |-> !rst_sync_n);
endmodule

bind page_mapper page_mapper_chk u_page_mapper_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .cpu_addr   (cpu_addr),
  .rd_n       (rd_n),
  .bank_sel_n (bank_sel_n),
  .rdata      (rdata),
  .rdata_oe   (rdata_oe),
  .phys_addr  (phys_addr),
  .map_en_q   (map_en_q),
  .commit_we  (commit_we)
);

// File: tb/test_page_mapper.sv
module test_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        rd_n, wr_n, bank_sel_n;
  logic [7:0]  rdata;
  logic        rdata_oe;
  logic [19:0] phys_addr;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] model [16];

  always #5 clk = ~clk;

  page_mapper i_page_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rd_n(rd_n), .wr_n(wr_n), .bank_sel_n(bank_sel_n),
    .rdata(rdata), .rdata_oe(rdata_oe), .phys_addr(phys_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; bank_sel_n = 1'b1;
    #1;
    chk("R9 phys page during async reset", 32'(phys_addr[19:12]), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg_write(input int idx, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = {4'(idx), 12'h0AB}; cpu_wdata = d;
    bank_sel_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    bank_sel_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_read(input int idx, input logic [7:0] exp, input string req);
    @(negedge clk);
    cpu_addr = {4'(idx), 12'h3C1};
    bank_sel_n = 1'b0; rd_n = 1'b0;
    #1;
    chk({req, " read oe"}, 32'(rdata_oe), 32'h1);
    chk({req, " read data"}, 32'(rdata), 32'(exp));
    @(negedge clk);
    bank_sel_n = 1'b1; rd_n = 1'b1;
    #1;
    chk("R4 oe drops after read", 32'(rdata_oe), 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    cpu_addr = 16'h0; cpu_wdata = 8'h0;
    do_reset();

    chk("R4 reset oe", 32'(rdata_oe), 32'h0);
    chk("R4 reset rdata", 32'(rdata), 32'h0);

    for (int i = 0; i < 16; i++) begin
      logic [11:0] off;
      off = 12'(12'h5A3 ^ (i * 291));
      cpu_addr = {4'(i), off};
      #1;
      chk("R5 disabled page zero", 32'(phys_addr[19:12]), 32'h0);
      chk("R1 offset pass-through", 32'(phys_addr[11:0]), 32'(off));
      @(negedge clk);
    end

    for (int i = 0; i < 16; i++) cfg_read(i, 8'h00, "R5 disabled");

    @(negedge clk);
    cpu_addr = 16'h9123; bank_sel_n = 1'b1; rd_n = 1'b0;
    #1;
    chk("R4 read without select oe", 32'(rdata_oe), 32'h0);
    rd_n = 1'b1;
    @(negedge clk);
    cpu_addr = 16'h6000; cpu_wdata = 8'h77; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 no enable after reads or unselected write", 32'(phys_addr[19:12]), 32'h0);

    for (int i = 0; i < 16; i++) begin
      model[i] = pat(i);
      cfg_write(i, model[i]);
    end

    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [11:0] off;
        off = 12'(k * 1365 + i);
        cpu_addr = {4'(i), off};
        #1;
        chk("R2 translation", 32'(phys_addr[19:12]), 32'(model[i]));
        chk("R1 offset pass-through", 32'(phys_addr[11:0]), 32'(off));
        @(negedge clk);
      end
    end
    for (int i = 0; i < 16; i++) cfg_read(i, model[i], "R4 enabled");

    @(negedge clk);
    cpu_addr = 16'h7456; cpu_wdata = 8'hC3; bank_sel_n = 1'b0; wr_n = 1'b0;
    #1;
    chk("R3 old entry during strobe", 32'(phys_addr[19:12]), 32'(model[7]));
    @(negedge clk);
    chk("R3 old entry after capture", 32'(phys_addr[19:12]), 32'(model[7]));
    bank_sel_n = 1'b1; wr_n = 1'b1;
    #1;
    chk("R3 old entry before end edge", 32'(phys_addr[19:12]), 32'(model[7]));
    @(negedge clk);
    model[7] = 8'hC3;
    chk("R3 new entry after end edge", 32'(phys_addr[19:12]), 32'hC3);

    @(negedge clk);
    cpu_addr = 16'h2010; cpu_wdata = 8'hEE; bank_sel_n = 1'b1; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cfg_read(2, model[2], "R8 unselected write ignored");

    do_reset();
    cpu_addr = 16'h9ABC;
    #1;
    chk("R5 disabled after second reset", 32'(phys_addr[19:12]), 32'h0);
    cfg_write(3, 8'h81);
    model[3] = 8'h81;
    cfg_read(9, model[9], "R7 entry kept across reset");
    cfg_read(7, model[7], "R7 rewritten entry kept across reset");
    cpu_addr = 16'h3FFF;
    #1;
    chk("R2 translation after re-enable", 32'(phys_addr), 32'h81FFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule